// File: doc/BRIEF.md
# Glyph Column Address Generator

This block forms the memory address used to fetch font columns for a scrolling LED display. Each glyph is stored as eight bytes, one byte per column. A glyph occupies eight consecutive locations, so its start address is the character code multiplied by eight. The controller clocks a character code into a holding shift register one bit at a time. A separate latch command then moves the complete code onto the address bus, so the bus never shows a code that is only partly shifted in.

A fetch command samples a small page number into the upper address bits and sets the column index to zero. After that, each column step produces one column strobe while the address shows the current column. The index then advances. The character code does not change between columns. After the strobe for the last column, a done pulse follows, and the block ignores further steps until the next fetch.

Top module: `glyph_col_addr_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `sram_addr` is 0, `col_valid` is 0 and `glyph_done` is 0.
- R2: Each cycle with `code_shift` high shifts `code_bit` into the holding register at the low end, so the first bit shifted becomes the MSB. After eight shifts and one `code_latch`, `sram_addr[10:3]` equals the eight bits in the order they were shifted.
- R3: `sram_addr[10:3]` changes only in the cycle after a `code_latch`; shifting alone leaves it unchanged.
- R4: `sram_addr[13:11]` takes the value of `page_sel` sampled in the cycle of `fetch_go`, and keeps it until the next `fetch_go`.
- R5: After `fetch_go`, each cycle with `col_step` high raises `col_valid` in that same cycle, while `sram_addr[2:0]` shows the current column. Columns are presented in order 0, 1, …, 7, and the next column is visible one cycle after the strobe.
- R6: The strobe for column 7 makes `glyph_done` high for exactly one cycle in the following cycle. The column index wraps to 0 without carrying into `sram_addr[10:3]`.
- R7: When no fetch is active, `col_step` raises no `col_valid` and leaves `sram_addr` unchanged.
- R8: `fetch_go` takes priority over `col_step` in the same cycle. No `col_valid` is raised in that cycle, and the column restarts at 0.
- R9: When `code_shift` and `code_latch` are high in the same cycle, the latched code is the register contents from before that cycle's shift.
- R10: A `code_latch` during a fetch updates `sram_addr[10:3]` and leaves the column index and the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_bit | input | 1 | Serial character code bit |
| code_shift | input | 1 | Shift enable for `code_bit` |
| code_latch | input | 1 | Move the holding register onto the address bus |
| page_sel | input | 3 | Page number, sampled on `fetch_go` |
| fetch_go | input | 1 | Start a glyph fetch at column 0 |
| col_step | input | 1 | Column advance enable |
| sram_addr | output | 14 | Address {page, code, column} |
| col_valid | output | 1 | Current address is a valid glyph column |
| glyph_done | output | 1 | One-cycle pulse after the last column |

## Verification
The sharp case is a restart colliding with a column advance. In that case `fetch_go` and `col_step` are high in the same cycle partway through a glyph. The bench forces this after three strobes. It expects no strobe in that cycle and column 0 with the new page on the next cycle. A second pairing, shift with latch, is provoked on a known register value. The bench judges it by the code that appears on the bus.

// File: rtl/glyph_addr_pkg.sv
package glyph_addr_pkg;
    localparam int CODE_W = 8;
    localparam int COL_W  = 3;
    localparam int PAGE_W = 3;
    localparam int ADDR_W = PAGE_W + CODE_W + COL_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [PAGE_W-1:0] page_t;

    localparam col_t COL_LAST = '1;

    typedef struct packed {
        page_t page;
        code_t code;
        col_t  col;
    } glyph_addr_t;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    function automatic col_t col_next(input col_t c);
        return c + col_t'(1);
    endfunction
endpackage

// File: rtl/glyph_code_shifter.sv
module glyph_code_shifter
    import glyph_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_in,
    input  logic  shift_en,
    input  logic  latch_en,
    output code_t code_q
);
    code_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            code_q <= '0;
        end else begin
            if (shift_en)
                hold_q <= {hold_q[CODE_W-2:0], bit_in};
            if (latch_en)
                code_q <= hold_q;
        end
    end
endmodule

// File: rtl/glyph_col_sequencer.sv
module glyph_col_sequencer
    import glyph_addr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step,
    output col_t col_q,
    output logic strobe,
    output logic done_q
);
    seq_state_e state_q;

    assign strobe = (state_q == SEQ_RUN) && step && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            col_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                col_q   <= '0;
                state_q <= SEQ_RUN;
            end else if (strobe) begin
                col_q <= col_next(col_q);
                if (col_q == COL_LAST) begin
                    state_q <= SEQ_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/glyph_addr_compose.sv
module glyph_addr_compose
    import glyph_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  page_t             page_in,
    input  code_t             code_in,
    input  col_t              col_in,
    output logic [ADDR_W-1:0] addr
);
    page_t       page_q;
    glyph_addr_t fields;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (start)
            page_q <= page_in;
    end

    assign fields.page = page_q;
    assign fields.code = code_in;
    assign fields.col  = col_in;
    assign addr        = fields;
endmodule

// File: rtl/glyph_col_addr_gen.sv
module glyph_col_addr_gen
    import glyph_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              code_bit,
    input  logic              code_shift,
    input  logic              code_latch,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              fetch_go,
    input  logic              col_step,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              col_valid,
    output logic              glyph_done
);
    code_t code_w;
    col_t  col_w;

    glyph_code_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (code_bit),
        .shift_en (code_shift),
        .latch_en (code_latch),
        .code_q   (code_w)
    );

    glyph_col_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (fetch_go),
        .step   (col_step),
        .col_q  (col_w),
        .strobe (col_valid),
        .done_q (glyph_done)
    );

    glyph_addr_compose u_addr (
        .clk     (clk),
        .rst     (rst),
        .start   (fetch_go),
        .page_in (page_sel),
        .code_in (code_w),
        .col_in  (col_w),
        .addr    (sram_addr)
    );
endmodule

// File: rtl/glyph_col_addr_gen_sva.sv
module glyph_col_addr_gen_sva
    import glyph_addr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              code_latch,
    input logic              fetch_go,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              col_valid,
    input logic              glyph_done
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sram_addr == '0 && !glyph_done));

    assert_code_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !code_latch |=> $stable(sram_addr[COL_W+CODE_W-1:COL_W]));

    assert_page_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !fetch_go |=> $stable(sram_addr[ADDR_W-1:COL_W+CODE_W]));

    assert_col_advance_R5: assert property (@(posedge clk) disable iff (rst)
        col_valid |=> (sram_addr[COL_W-1:0] == $past(sram_addr[COL_W-1:0]) + col_t'(1)));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        glyph_done |-> ($past(col_valid) && $past(sram_addr[COL_W-1:0]) == COL_LAST));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        glyph_done |=> !glyph_done);

    assert_restart_wins_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_go |-> !col_valid);
endmodule

bind glyph_col_addr_gen glyph_col_addr_gen_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .code_latch (code_latch),
    .fetch_go   (fetch_go),
    .sram_addr  (sram_addr),
    .col_valid  (col_valid),
    .glyph_done (glyph_done)
);

// File: tb/test_glyph_col_addr_gen.sv
`timescale 1ns/100ps
module test_glyph_col_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_bit = 1'b0, code_shift = 1'b0, code_latch = 1'b0;
    logic [2:0]  page_sel = 3'd0;
    logic        fetch_go = 1'b0, col_step = 1'b0;
    logic [13:0] sram_addr;
    logic        col_valid, glyph_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    glyph_col_addr_gen i_glyph_col_addr_gen (
        .clk(clk), .rst(rst), .code_bit(code_bit), .code_shift(code_shift),
        .code_latch(code_latch), .page_sel(page_sel), .fetch_go(fetch_go),
        .col_step(col_step), .sram_addr(sram_addr), .col_valid(col_valid),
        .glyph_done(glyph_done)
    );

    // {page, code} per glyph fetch
    localparam logic [10:0] VEC [4] = '{
        {3'd0, 8'h41}, {3'd5, 8'hFF}, {3'd7, 8'h00}, {3'd2, 8'hA5}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_code(input logic [7:0] c);
        for (int i = 7; i >= 0; i--) begin
            code_shift = 1'b1;
            code_bit   = c[i];
            tick();
        end
        code_shift = 1'b0;
        code_bit   = 1'b0;
    endtask

    task automatic latch();
        code_latch = 1'b1;
        tick();
        code_latch = 1'b0;
    endtask

    task automatic start_fetch(input logic [2:0] p);
        page_sel = p;
        fetch_go = 1'b1;
        tick();
        fetch_go = 1'b0;
        page_sel = ~p;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev_code;
        tick();
        // R1: reset state
        check("R1 addr", 32'(sram_addr), 0);
        check("R1 valid", 32'(col_valid), 0);
        check("R1 done", 32'(glyph_done), 0);
        tick();
        rst = 1'b0;
        tick();
        check("R1 addr after release", 32'(sram_addr), 0);

        // R7: step while idle
        col_step = 1'b1;
        #1 check("R7 no strobe idle", 32'(col_valid), 0);
        tick();
        col_step = 1'b0;
        check("R7 addr unchanged", 32'(sram_addr), 0);

        prev_code = 8'h00;
        foreach (VEC[v]) begin
            logic [2:0] p;
            logic [7:0] c;
            p = VEC[v][10:8];
            c = VEC[v][7:0];
            shift_code(c);
            check("R3 code held during shift", 32'(sram_addr[10:3]), 32'(prev_code));
            latch();
            check("R2 code latched MSB first", 32'(sram_addr[10:3]), 32'(c));
            start_fetch(p);
            for (int col = 0; col < 8; col++) begin
                col_step = 1'b1;
                #1;
                check("R5 strobe", 32'(col_valid), 1);
                check("R5 addr", 32'(sram_addr), 32'({p, c, 3'(col)}));
                tick();
                col_step = 1'b0;
            end
            check("R6 done pulse", 32'(glyph_done), 1);
            check("R6 wrap no carry", 32'(sram_addr), 32'({p, c, 3'd0}));
            check("R4 page held", 32'(sram_addr[13:11]), 32'(p));
            tick();
            check("R6 done one cycle", 32'(glyph_done), 0);
            col_step = 1'b1;
            #1 check("R6 no strobe after last", 32'(col_valid), 0);
            tick();
            col_step = 1'b0;
            check("R7 addr frozen", 32'(sram_addr), 32'({p, c, 3'd0}));
            prev_code = c;
        end

        // R8: restart collides with step mid-glyph
        start_fetch(3'd1);
        col_step = 1'b1;
        tick(); tick(); tick();
        check("R8 pre-collision column", 32'(sram_addr[2:0]), 3);
        fetch_go = 1'b1;
        page_sel = 3'd6;
        #1 check("R8 no strobe on restart", 32'(col_valid), 0);
        tick();
        fetch_go = 1'b0;
        col_step = 1'b0;
        check("R8 column restarted", 32'(sram_addr[2:0]), 0);
        check("R4 new page", 32'(sram_addr[13:11]), 6);

        // R10: latch mid-fetch
        col_step = 1'b1;
        tick(); tick();
        col_step = 1'b0;
        shift_code(8'h3C);
        check("R10 column before latch", 32'(sram_addr[2:0]), 2);
        latch();
        check("R10 code updated", 32'(sram_addr[10:3]), 32'h3C);
        check("R10 column kept", 32'(sram_addr[2:0]), 2);
        col_step = 1'b1;
        #1 check("R10 sequence continues", 32'(col_valid), 1);
        tick();
        col_step = 1'b0;
        check("R10 next column", 32'(sram_addr[2:0]), 3);

        // R9: shift and latch same cycle, holding reg = 3C
        code_shift = 1'b1;
        code_bit   = 1'b1;
        code_latch = 1'b1;
        tick();
        code_shift = 1'b0;
        code_bit   = 1'b0;
        code_latch = 1'b0;
        check("R9 old contents latched", 32'(sram_addr[10:3]), 32'h3C);
        latch();
        check("R9 shifted value later", 32'(sram_addr[10:3]), 32'h79);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule